// File: doc/BRIEF.md
# Receiver Detection and Termination Sequencer

This block controls the link-side terminations of a four-lane signal repeater. The lanes form two groups of two: group A holds lanes 0 and 1, and group B holds lanes 2 and 3. An active-low strobe asks for a receiver detection run. On the release of that strobe the block ramps the transmit common mode up and then down. At the end of the ramp-up phase it latches the result of an external analog probe for each lane. From the latched results it sets, per group, whether the receive inputs are terminated or left floating, and per lane, whether the transmitter drives into 50 Ω or rests at a weak 1 kΩ termination.

A group whose detect enable is low skips the probe and terminates at once. A group that finds no receiver on either lane floats its inputs. The block also enforces the timing rules for the strobe and the enables. A strobe pulse that is too short is ignored. An enable that rises too late before the release, or drops too soon after it, aborts that group's run and records a sticky error. Every time interval is a count of clock cycles, derived from a clock-frequency parameter and a duration in nanoseconds.

Top module: `rxdet_term_seq`

## Requirements
- R1: While `pwr_dn_n` is low, the following outputs take effect in the same cycle: `rx_term_on` = 0, `tx_term_50` = 0, `tx_squelch` all ones and `cm_mode` = 0 (rail). After the next clock edge, `grp_done`, `rx_present` and `timing_err` are all zero.
- R2: While `det_strobe_n` is low, the outputs are forced as follows: `rx_term_on` = 0, `tx_term_50` = 0, `tx_squelch` all ones and `cm_mode` = 0.
- R3: A run starts on the release of a low pulse that lasted at least MIN_LOW cycles. `cm_mode` reads 1 (ramp-up) for RAMP_UP cycles, starting one cycle after the release. It then reads 2 (ramp-down) for RAMP_DN cycles, and then 3 (active). `grp_done` rises in the same cycle that the active code appears.
- R4: A low pulse shorter than MIN_LOW cycles starts no run. The previous results, terminations and `cm_mode` are unchanged once the strobe returns high.
- R5: `probe_hit` is sampled in the last ramp-up cycle. It is held in `rx_present` (bit 0 = lane A0, bit 1 = A1, bit 2 = B0, bit 3 = B1) until the next run starts. Later changes of `probe_hit` have no effect.
- R6: A group whose enable is high, and in which neither lane has a receiver, leaves its `rx_term_on` bit at 0 (hi-Z). Both of its lanes get `tx_term_50` = 0 and are squelched.
- R7: A group whose enable is low at the start of a run gets `rx_term_on` = 1 and `tx_term_50` = 1 on both lanes. Its `rx_present` bits are 0, and its done bit is set at the end of the run (`det_en`/`rx_term_on` bit 0 = group A, bit 1 = group B).
- R8: In a group where a receiver was found, `rx_term_on` is 1. A lane with a receiver has `tx_term_50` = 1 and `tx_squelch` equal to its `lane_idle`. A lane without a receiver has `tx_term_50` = 0 and is squelched.
- R9: An enable that has been high for fewer than EN_SETUP cycles at the release aborts that group. So does an enable that drops within EN_HOLD cycles after the release. An aborted group floats its inputs, clears its `rx_present` bits, sets its done bit and sets its `timing_err` bit. That bit stays set until power-down or reset.
- R10: A strobe that goes low during a ramp phase cancels the run. `cm_mode` returns to 0, and the probing groups return to hi-Z with done 0.
- R11: After reset, and before the first run, all receive inputs are hi-Z, all transmitters are at 1 kΩ and squelched, and `cm_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down, overrides everything |
| det_strobe_n | input | 1 | Active-low detect strobe; release starts a run |
| det_en | input | 2 | Detect enable per group (bit 0 = A, bit 1 = B) |
| probe_hit | input | 4 | Analog probe result per lane |
| lane_idle | input | 4 | Electrical-idle flag per lane |
| rx_term_on | output | 2 | Per group: 1 = 50 Ω receive termination, 0 = hi-Z |
| tx_term_50 | output | 4 | Per lane: 1 = 50 Ω transmit termination, 0 = 1 kΩ |
| tx_squelch | output | 4 | Per lane: transmitter held quiet |
| cm_mode | output | 2 | Common mode: 0 rail, 1 ramp-up, 2 ramp-down, 3 active |
| grp_done | output | 2 | Per-group run finished |
| rx_present | output | 4 | Per-lane latched receiver result |
| timing_err | output | 2 | Per-group sticky enable timing violation |

## Verification
The termination and squelch outputs respond in the same cycle to power-down and to the strobe level. Status bits follow one edge after a cause. The ramp codes appear one edge after the release and change on exact cycle boundaries: ramp-up lasts from cycles 1 to RAMP_UP, ramp-down follows, and `grp_done` rises with the active code. The bench drives all inputs on falling edges and counts falling edges from the release. It samples the ramp phase boundaries exactly at their first and last cycles. It reads settled run results only after the enable-hold window has closed, and it changes `probe_hit` after the sampling cycle to show that the change has no effect.

// File: rtl/rxdet_pkg.sv
// Shared types and helpers for the receiver detection sequencer.
// Assumes durations are given in ns and the clock in MHz.
package rxdet_pkg;

    typedef enum logic [1:0] {
        CM_RAIL    = 2'd0,
        CM_RAMP_UP = 2'd1,
        CM_RAMP_DN = 2'd2,
        CM_ACTIVE  = 2'd3
    } cm_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_UP   = 2'd1,
        SEQ_DN   = 2'd2,
        SEQ_DONE = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        GRP_OFF    = 3'd0,
        GRP_BYPASS = 3'd1,
        GRP_PROBE  = 3'd2,
        GRP_FOUND  = 3'd3,
        GRP_NONE   = 3'd4,
        GRP_ABORT  = 3'd5
    } grp_state_e;

    // Convert a duration in ns into clock cycles, rounding up, at least one.
    function automatic int ns_to_cyc(input longint dur_ns, input longint clk_mhz);
        longint c;
        c = (dur_ns * clk_mhz + 64'd999) / 64'd1000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/rxdet_strobe_qual.sv
// Measures the low width of the detect strobe and emits a one-cycle start
// pulse on its release when the low phase lasted at least MIN_LOW_CYC cycles.
// Assumes the strobe is already synchronous to clk.
module rxdet_strobe_qual #(
    parameter int MIN_LOW_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic strobe_n,
    output logic start
);
    localparam int CW = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(MIN_LOW_CYC);

    logic          strb_q;
    logic [CW-1:0] low_cnt;

    // Track previous strobe level and count saturating low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            strb_q  <= 1'b1;
            low_cnt <= '0;
        end else begin
            strb_q <= strobe_n;
            if (!strobe_n) begin
                if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
            end
        end
    end

    // Qualified release edge.
    assign start = !clr && strobe_n && !strb_q && (low_cnt == LIM);

endmodule

// File: rtl/rxdet_en_guard.sv
// Per-group enable timing guard. Reports whether the enable has been high
// long enough before a start and flags a drop inside the hold window that
// follows an accepted start. Assumes start is a single-cycle pulse.
module rxdet_en_guard #(
    parameter int SETUP_CYC = 50,
    parameter int HOLD_CYC  = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic start,
    output logic setup_ok,
    output logic viol
);
    localparam int SW = $clog2(SETUP_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [SW-1:0] SLIM = SW'(SETUP_CYC);
    localparam logic [HW-1:0] HLAST = HW'(HOLD_CYC - 1);

    logic [SW-1:0] set_cnt;
    logic [HW-1:0] hold_cnt;
    logic          armed;

    // Count how long the enable has been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  set_cnt <= '0;
        else if (!en)       set_cnt <= '0;
        else if (set_cnt != SLIM) set_cnt <= set_cnt + 1'b1;
    end

    assign setup_ok = (set_cnt == SLIM);
    assign viol     = armed && !en;

    // Run the hold window after an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            armed    <= 1'b0;
            hold_cnt <= '0;
        end else if (start && en && setup_ok) begin
            armed    <= 1'b1;
            hold_cnt <= '0;
        end else if (armed) begin
            if (!en || hold_cnt == HLAST) armed <= 1'b0;
            else                          hold_cnt <= hold_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rxdet_phase_ctrl.sv
// Shared ramp sequencer: ramp-up for UP_CYC cycles, ramp-down for DN_CYC
// cycles, then active. Emits the probe sample strobe on the last ramp-up
// cycle, a finish strobe on the last ramp-down cycle, and a cancel strobe
// when the detect strobe drops during a ramp. Assumes UP_CYC, DN_CYC >= 1.
module rxdet_phase_ctrl
    import rxdet_pkg::*;
#(
    parameter int UP_CYC = 200000,
    parameter int DN_CYC = 375
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     start,
    input  logic     strobe_low,
    output cm_mode_e cm,
    output logic     sample,
    output logic     finish,
    output logic     cancel
);
    localparam int MAXC = (UP_CYC > DN_CYC) ? UP_CYC : DN_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] UP_LAST = CW'(UP_CYC - 1);
    localparam logic [CW-1:0] DN_LAST = CW'(DN_CYC - 1);

    seq_state_e    st;
    logic [CW-1:0] cnt;

    // Phase state and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else if (start) begin
            st  <= SEQ_UP;
            cnt <= '0;
        end else begin
            case (st)
                SEQ_UP: begin
                    if (strobe_low) begin
                        st <= SEQ_IDLE;
                    end else if (cnt == UP_LAST) begin
                        st  <= SEQ_DN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_DN: begin
                    if (strobe_low) begin
                        st <= SEQ_IDLE;
                    end else if (cnt == DN_LAST) begin
                        st  <= SEQ_DONE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // Decode the phase into the common-mode code and strobes.
    always_comb begin
        case (st)
            SEQ_UP:   cm = CM_RAMP_UP;
            SEQ_DN:   cm = CM_RAMP_DN;
            SEQ_DONE: cm = CM_ACTIVE;
            default:  cm = CM_RAIL;
        endcase
    end

    assign cancel = (st == SEQ_UP || st == SEQ_DN) && strobe_low;
    assign sample = (st == SEQ_UP) && !strobe_low && (cnt == UP_LAST);
    assign finish = (st == SEQ_DN) && !strobe_low && (cnt == DN_LAST);

endmodule

// File: rtl/rxdet_group_term.sv
// One lane group's detection result and termination control. Decides the
// group state at a run start, latches probe results on the sample strobe,
// aborts on enable timing violations and drives terminations and squelch.
// Assumes force covers power-down and strobe-low conditions.
module rxdet_group_term
    import rxdet_pkg::*;
#(
    parameter int LPG = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           force_off,
    input  logic           start,
    input  logic           en,
    input  logic           setup_ok,
    input  logic           viol,
    input  logic           sample,
    input  logic           finish,
    input  logic           cancel,
    input  logic [LPG-1:0] probe,
    input  logic [LPG-1:0] idle,
    output logic           rx_on,
    output logic [LPG-1:0] tx50,
    output logic [LPG-1:0] squelch,
    output logic           done,
    output logic [LPG-1:0] present,
    output logic           err
);
    grp_state_e st;
    logic       probing;

    assign probing = (st == GRP_PROBE) || (st == GRP_FOUND) || (st == GRP_NONE);

    // Group state, latched results and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st      <= GRP_OFF;
            done    <= 1'b0;
            present <= '0;
            err     <= 1'b0;
        end else if (start) begin
            present <= '0;
            done    <= 1'b0;
            if (!en) begin
                st <= GRP_BYPASS;
            end else if (!setup_ok) begin
                st   <= GRP_ABORT;
                err  <= 1'b1;
                done <= 1'b1;
            end else begin
                st <= GRP_PROBE;
            end
        end else if (viol && probing) begin
            st      <= GRP_ABORT;
            err     <= 1'b1;
            done    <= 1'b1;
            present <= '0;
        end else if (cancel && probing && !done) begin
            st      <= GRP_OFF;
            present <= '0;
        end else begin
            if (sample && st == GRP_PROBE) begin
                present <= probe;
                st      <= (|probe) ? GRP_FOUND : GRP_NONE;
            end
            if (finish && st != GRP_ABORT && st != GRP_OFF) done <= 1'b1;
        end
    end

    // Terminations and squelch from the group state.
    always_comb begin
        rx_on = 1'b0;
        tx50  = '0;
        if (!force_off) begin
            if (st == GRP_BYPASS) begin
                rx_on = 1'b1;
                tx50  = '1;
            end else if (st == GRP_FOUND) begin
                rx_on = 1'b1;
                tx50  = present;
            end
        end
        squelch = ~tx50 | idle;
    end

endmodule

// File: rtl/rxdet_term_seq.sv
// Top level: receiver detection and termination sequencer for GROUPS lane
// groups of LANES_PER_GROUP lanes. Converts ns durations into cycle counts,
// shares one strobe qualifier and ramp sequencer, and instantiates an
// enable guard and a termination controller per group.
// Assumes all inputs are synchronous to clk.
module rxdet_term_seq
    import rxdet_pkg::*;
#(
    parameter int CLK_MHZ         = 250,
    parameter int MIN_LOW_NS      = 200,
    parameter int EN_SETUP_NS     = 200,
    parameter int EN_HOLD_NS      = 2000000,
    parameter int RAMP_UP_NS      = 800000,
    parameter int RAMP_DN_NS      = 1500,
    parameter int GROUPS          = 2,
    parameter int LANES_PER_GROUP = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                pwr_dn_n,
    input  logic                                det_strobe_n,
    input  logic [GROUPS-1:0]                   det_en,
    input  logic [GROUPS*LANES_PER_GROUP-1:0]   probe_hit,
    input  logic [GROUPS*LANES_PER_GROUP-1:0]   lane_idle,
    output logic [GROUPS-1:0]                   rx_term_on,
    output logic [GROUPS*LANES_PER_GROUP-1:0]   tx_term_50,
    output logic [GROUPS*LANES_PER_GROUP-1:0]   tx_squelch,
    output logic [1:0]                          cm_mode,
    output logic [GROUPS-1:0]                   grp_done,
    output logic [GROUPS*LANES_PER_GROUP-1:0]   rx_present,
    output logic [GROUPS-1:0]                   timing_err
);
    localparam int LPG        = LANES_PER_GROUP;
    localparam int MIN_LOW_C  = ns_to_cyc(MIN_LOW_NS, CLK_MHZ);
    localparam int SETUP_C    = ns_to_cyc(EN_SETUP_NS, CLK_MHZ);
    localparam int HOLD_C     = ns_to_cyc(EN_HOLD_NS, CLK_MHZ);
    localparam int UP_C       = ns_to_cyc(RAMP_UP_NS, CLK_MHZ);
    localparam int DN_C       = ns_to_cyc(RAMP_DN_NS, CLK_MHZ);

    logic     pd;
    logic     force_off;
    logic     start;
    logic     sample;
    logic     finish;
    logic     cancel;
    cm_mode_e phase_cm;
    logic [GROUPS-1:0] setup_ok;
    logic [GROUPS-1:0] viol;

    assign pd        = !pwr_dn_n;
    assign force_off = pd || !det_strobe_n;

    rxdet_strobe_qual #(.MIN_LOW_CYC(MIN_LOW_C)) i_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pd),
        .strobe_n (det_strobe_n),
        .start    (start)
    );

    rxdet_phase_ctrl #(.UP_CYC(UP_C), .DN_CYC(DN_C)) i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (pd),
        .start      (start),
        .strobe_low (!det_strobe_n),
        .cm         (phase_cm),
        .sample     (sample),
        .finish     (finish),
        .cancel     (cancel)
    );

    // Common mode sits at the rail whenever outputs are forced off.
    assign cm_mode = force_off ? CM_RAIL : phase_cm;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        rxdet_en_guard #(.SETUP_CYC(SETUP_C), .HOLD_CYC(HOLD_C)) i_guard (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (pd),
            .en       (det_en[g]),
            .start    (start),
            .setup_ok (setup_ok[g]),
            .viol     (viol[g])
        );

        rxdet_group_term #(.LPG(LPG)) i_term (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (pd),
            .force_off (force_off),
            .start     (start),
            .en        (det_en[g]),
            .setup_ok  (setup_ok[g]),
            .viol      (viol[g]),
            .sample    (sample),
            .finish    (finish),
            .cancel    (cancel),
            .probe     (probe_hit[g*LPG +: LPG]),
            .idle      (lane_idle[g*LPG +: LPG]),
            .rx_on     (rx_term_on[g]),
            .tx50      (tx_term_50[g*LPG +: LPG]),
            .squelch   (tx_squelch[g*LPG +: LPG]),
            .done      (grp_done[g]),
            .present   (rx_present[g*LPG +: LPG]),
            .err       (timing_err[g])
        );
    end

endmodule

// File: rtl/rxdet_term_seq_chk.sv
// Assertion checker for the sequencer top, attached with bind below.
module rxdet_term_seq_chk #(
    parameter int GROUPS          = 2,
    parameter int LANES_PER_GROUP = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              pwr_dn_n,
    input logic                              det_strobe_n,
    input logic [GROUPS-1:0]                 det_en,
    input logic [GROUPS*LANES_PER_GROUP-1:0] probe_hit,
    input logic [GROUPS*LANES_PER_GROUP-1:0] lane_idle,
    input logic [GROUPS-1:0]                 rx_term_on,
    input logic [GROUPS*LANES_PER_GROUP-1:0] tx_term_50,
    input logic [GROUPS*LANES_PER_GROUP-1:0] tx_squelch,
    input logic [1:0]                        cm_mode,
    input logic [GROUPS-1:0]                 grp_done,
    input logic [GROUPS*LANES_PER_GROUP-1:0] rx_present,
    input logic [GROUPS-1:0]                 timing_err
);
    localparam int LPG = LANES_PER_GROUP;

    AST_PD_TERM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |-> (rx_term_on == '0 && tx_term_50 == '0 && cm_mode == 2'd0)); // R1

    AST_PD_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> (grp_done == '0 && rx_present == '0 && timing_err == '0)); // R1

    AST_STROBE_LOW_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        !det_strobe_n |-> (rx_term_on == '0 && tx_term_50 == '0 && cm_mode == 2'd0)); // R2

    AST_UP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_mode == 2'd1) |=> (cm_mode == 2'd1 || cm_mode == 2'd2 || cm_mode == 2'd0)); // R3

    AST_DN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_mode == 2'd2) |=> (cm_mode == 2'd2 || cm_mode == 2'd3 || cm_mode == 2'd0)); // R3

    AST_UNSQUELCH_NEEDS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        ((~tx_squelch & ~tx_term_50) == '0)); // R8

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        AST_TX_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_term_50[g*LPG +: LPG] != '0) |-> rx_term_on[g]); // R8

        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(timing_err[g]) |-> !$past(pwr_dn_n)); // R9
    end

endmodule

bind rxdet_term_seq rxdet_term_seq_chk #(
    .GROUPS          (GROUPS),
    .LANES_PER_GROUP (LANES_PER_GROUP)
) i_chk (.*);

// File: tb/test_rxdet_term_seq.sv
module test_rxdet_term_seq;
    // Scaled timing: 10 cycles min pulse/setup, 200 hold, 100 up, 10 down.
    localparam int UPC  = 100;
    localparam int DNC  = 10;

    logic       clk = 1'b0;
    logic       rst_n, pwr_dn_n, det_strobe_n;
    logic [1:0] det_en;
    logic [3:0] probe_hit, lane_idle;
    logic [1:0] rx_term_on, cm_mode, grp_done, timing_err;
    logic [3:0] tx_term_50, tx_squelch, rx_present;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rxdet_term_seq #(
        .CLK_MHZ(250), .MIN_LOW_NS(40), .EN_SETUP_NS(40), .EN_HOLD_NS(800),
        .RAMP_UP_NS(400), .RAMP_DN_NS(40)
    ) i_rxdet_term_seq (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .det_strobe_n(det_strobe_n),
        .det_en(det_en), .probe_hit(probe_hit), .lane_idle(lane_idle),
        .rx_term_on(rx_term_on), .tx_term_50(tx_term_50), .tx_squelch(tx_squelch),
        .cm_mode(cm_mode), .grp_done(grp_done), .rx_present(rx_present),
        .timing_err(timing_err)
    );

    // Vector: en[23:22] probe[21:18] idle[17:14] | rx[13:12] tx[11:8] sq[7:4] pres[3:0]
    localparam logic [23:0] VEC [8] = '{
        {2'b11, 4'b1111, 4'b0000, 2'b11, 4'b1111, 4'b0000, 4'b1111},
        {2'b11, 4'b0001, 4'b0000, 2'b01, 4'b0001, 4'b1110, 4'b0001},
        {2'b11, 4'b0000, 4'b0000, 2'b00, 4'b0000, 4'b1111, 4'b0000},
        {2'b00, 4'b1111, 4'b0000, 2'b11, 4'b1111, 4'b0000, 4'b0000},
        {2'b01, 4'b1000, 4'b0000, 2'b10, 4'b1100, 4'b0011, 4'b0000},
        {2'b10, 4'b0110, 4'b0000, 2'b11, 4'b0111, 4'b1000, 4'b0100},
        {2'b11, 4'b1010, 4'b1000, 2'b11, 4'b1010, 4'b1101, 4'b1010},
        {2'b11, 4'b1111, 4'b0110, 2'b11, 4'b1111, 4'b0110, 4'b1111}
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Low pulse of the given number of cycles, released on a falling edge.
    task automatic pulse(input int low);
        det_strobe_n = 1'b0;
        repeat (low) @(negedge clk);
        det_strobe_n = 1'b1;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_dn_n = 1'b1; det_strobe_n = 1'b1;
        det_en = 2'b00; probe_hit = 4'h0; lane_idle = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: state before any run
        check("R11", "rx_term_on", 8'(rx_term_on), 8'h0);
        check("R11", "tx_term_50", 8'(tx_term_50), 8'h0);
        check("R11", "tx_squelch", 8'(tx_squelch), 8'hF);
        check("R11", "cm_mode", 8'(cm_mode), 8'd0);
        check("R11", "grp_done", 8'(grp_done), 8'h0);

        // R3 / R5: phase timing and sample point
        det_en = 2'b11; probe_hit = 4'hF;
        repeat (20) @(negedge clk);
        det_strobe_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2", "cm_mode while low", 8'(cm_mode), 8'd0);
        check("R2", "rx_term_on while low", 8'(rx_term_on), 8'h0);
        check("R2", "tx_squelch while low", 8'(tx_squelch), 8'hF);
        repeat (9) @(negedge clk);
        det_strobe_n = 1'b1;
        @(negedge clk);
        check("R3", "cm first up cycle", 8'(cm_mode), 8'd1);
        repeat (UPC - 1) @(negedge clk);
        check("R3", "cm last up cycle", 8'(cm_mode), 8'd1);
        @(negedge clk);
        check("R3", "cm first down cycle", 8'(cm_mode), 8'd2);
        probe_hit = 4'h0;
        repeat (DNC - 1) @(negedge clk);
        check("R3", "cm last down cycle", 8'(cm_mode), 8'd2);
        check("R3", "done before end", 8'(grp_done), 8'h0);
        @(negedge clk);
        check("R3", "cm active", 8'(cm_mode), 8'd3);
        check("R3", "done at end", 8'(grp_done), 8'h3);
        check("R5", "present latched", 8'(rx_present), 8'hF);
        repeat (109) @(negedge clk);

        // Vector table: R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            det_en = VEC[i][23:22]; probe_hit = VEC[i][21:18]; lane_idle = VEC[i][17:14];
            repeat (20) @(negedge clk);
            pulse(12);
            repeat (220) @(negedge clk);
            check("R6/R7/R8", $sformatf("vec%0d rx_term_on", i), 8'(rx_term_on), 8'(VEC[i][13:12]));
            check("R6/R7/R8", $sformatf("vec%0d tx_term_50", i), 8'(tx_term_50), 8'(VEC[i][11:8]));
            check("R8", $sformatf("vec%0d tx_squelch", i), 8'(tx_squelch), 8'(VEC[i][7:4]));
            check("R5", $sformatf("vec%0d rx_present", i), 8'(rx_present), 8'(VEC[i][3:0]));
            check("R7", $sformatf("vec%0d grp_done", i), 8'(grp_done), 8'h3);
            check("R9", $sformatf("vec%0d timing_err", i), 8'(timing_err), 8'h0);
        end

        // R4: short pulse ignored
        lane_idle = 4'h0;
        pulse(9);
        @(negedge clk);
        check("R4", "cm after short pulse", 8'(cm_mode), 8'd3);
        repeat (5) @(negedge clk);
        check("R4", "present kept", 8'(rx_present), 8'hF);
        check("R4", "rx kept", 8'(rx_term_on), 8'h3);

        // R10: strobe low during ramp-up cancels
        pulse(12);
        repeat (50) @(negedge clk);
        check("R10", "mid run cm", 8'(cm_mode), 8'd1);
        pulse(4);
        repeat (3) @(negedge clk);
        check("R10", "cm after cancel", 8'(cm_mode), 8'd0);
        check("R10", "done after cancel", 8'(grp_done), 8'h0);
        check("R10", "rx after cancel", 8'(rx_term_on), 8'h0);

        // R9: hold violation on group B
        repeat (210) @(negedge clk);
        pulse(12);
        repeat (50) @(negedge clk);
        det_en = 2'b01;
        repeat (170) @(negedge clk);
        check("R9", "hold err", 8'(timing_err), 8'h2);
        check("R9", "hold done", 8'(grp_done), 8'h3);
        check("R9", "hold rx", 8'(rx_term_on), 8'h1);
        check("R9", "hold present", 8'(rx_present), 8'h3);

        // R1: power-down override
        pwr_dn_n = 1'b0;
        #1;
        check("R1", "pd rx", 8'(rx_term_on), 8'h0);
        check("R1", "pd tx", 8'(tx_term_50), 8'h0);
        check("R1", "pd cm", 8'(cm_mode), 8'd0);
        @(negedge clk);
        check("R1", "pd err", 8'(timing_err), 8'h0);
        check("R1", "pd present", 8'(rx_present), 8'h0);
        check("R1", "pd done", 8'(grp_done), 8'h0);
        pwr_dn_n = 1'b1;

        // R9: setup violation on group B
        repeat (20) @(negedge clk);
        det_strobe_n = 1'b0;
        repeat (9) @(negedge clk);
        det_en = 2'b11;
        repeat (3) @(negedge clk);
        det_strobe_n = 1'b1;
        repeat (220) @(negedge clk);
        check("R9", "setup err", 8'(timing_err), 8'h2);
        check("R9", "setup rx", 8'(rx_term_on), 8'h1);
        check("R9", "setup present", 8'(rx_present), 8'h3);

        // R9: error stays set across a clean run
        pulse(12);
        repeat (220) @(negedge clk);
        check("R9", "sticky err", 8'(timing_err), 8'h2);
        check("R8", "clean run rx", 8'(rx_term_on), 8'h3);

        summary();
        $finish;
    end

endmodule